// File: doc/BRIEF.md
# Bidirectional Rational Pulse Scaler

This block takes a stream of one-cycle step strobes, each tagged with a direction, and turns it into a thinner stream of step strobes at a programmable ratio Num/Den with Num below Den. One modular accumulator decides where each output strobe falls. It uses only an adder, a subtractor and a sign test. Across any Den input steps in one direction, exactly Num output steps come out, and they are spread as evenly as whole steps allow.

Forward and reverse steps work on the same accumulator. A forward step adds Num, and a reverse step takes Num away. Each wrap past the modulus produces one output step in the matching direction. A change of direction therefore carries the partial count forward instead of losing it. The ratio is taken only on a load strobe. The load also clears the accumulator. A ratio that cannot be used keeps the output silent until the next load.

Top module: `frac_pulse_scaler`

## Requirements
- R1: After reset, pulse_o is 0, dir_o is 1 (forward), the accumulator is 0, and the stored ratio is unusable, so no output step appears until a load.
- R2: When load_i is 1, num_i and den_i are stored and the accumulator is cleared to 0. An input step in the same cycle as load_i is ignored: it gives no output step and leaves no residue.
- R3: A forward step (dir_i = 1) adds Num to the accumulator. If the sum is Den or more, Den is subtracted and a forward output step is produced.
- R4: A reverse step (dir_i = 0) subtracts Num from the accumulator. If the result is below zero, Den is added and a reverse output step is produced.
- R5: Starting from a cleared accumulator, Den steps in one direction give exactly Num output steps. For 5/13 forward, the outputs follow input steps 3, 6, 8, 11 and 13. For 5/13 reverse, they follow steps 1, 3, 6, 8 and 11.
- R6: Both directions share one accumulator. With 5/13, three forward steps leave a residue of 2. A reverse step then gives a reverse output and a residue of 10. A forward step after that gives a forward output.
- R7: A stored ratio with Den = 0 or Num >= Den produces no output step, for any number of input steps.
- R8: An output step is a single pulse_o cycle one clock after the accepted input step, with at most one per input step. dir_o takes that step's direction on the same edge and holds it until the next accepted step.
- R9: Cycles with pulse_i = 0 produce no output step and leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | One-cycle input step strobe |
| dir_i | input | 1 | Input step direction: 1 forward, 0 reverse |
| load_i | input | 1 | Store num_i and den_i and clear the accumulator |
| num_i | input | W | Ratio numerator |
| den_i | input | W | Ratio denominator (modulus) |
| pulse_o | output | 1 | One-cycle output step strobe |
| dir_o | output | 1 | Direction of the latest accepted step |

## Verification
Every result appears one clock after the edge that samples its cause. An accepted step shows on pulse_o and dir_o after that edge. A load takes effect from the next step. The bench drives its inputs on falling edges and reads pulse_o and dir_o on the next falling edge, so each reading belongs to exactly one sampling edge. Accumulator state is never read directly. Residue and clearing are inferred from which later step produces the next output.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } dir_e;
endpackage

// File: rtl/fps_ratio_reg.sv
module fps_ratio_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] num_o,
  output logic [W-1:0] den_o,
  output logic         valid_o
);
  logic [W-1:0] num_q, den_q;
  logic         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q   <= '0;
      den_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      num_q   <= num_i;
      den_q   <= den_i;
      valid_q <= (den_i != '0) && (num_i < den_i);
    end
  end

  assign num_o   = num_q;
  assign den_o   = den_q;
  assign valid_o = valid_q;

  // R7: an unusable ratio is never marked valid
  assert_bad_ratio_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ((den_i == '0) || (num_i >= den_i)) |=> !valid_o);
endmodule

// File: rtl/fps_mod_acc.sv
module fps_mod_acc #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic         dir_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         wrap_o,
  output logic [W:0]   acc_o
);
  import fps_pkg::*;
  localparam int ACC_W = W + 1;
  localparam int SUM_W = W + 2;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] acc_x, num_x, den_x;
  logic [SUM_W-1:0] fwd_raw, fwd_sub, rev_raw, rev_add;
  logic             fwd_wrap, rev_wrap;

  assign acc_x = {1'b0, acc_q};
  assign num_x = {2'b00, num_i};
  assign den_x = {2'b00, den_i};

  // two adders per direction, select on sign
  assign fwd_raw  = acc_x + num_x;
  assign fwd_sub  = fwd_raw - den_x;
  assign fwd_wrap = !fwd_sub[SUM_W-1];
  assign rev_raw  = acc_x - num_x;
  assign rev_add  = rev_raw + den_x;
  assign rev_wrap = rev_raw[SUM_W-1];

  always_comb begin
    acc_d  = acc_q;
    wrap_o = 1'b0;
    if (step_i) begin
      if (dir_e'(dir_i) == DIR_FWD) begin
        wrap_o = fwd_wrap;
        acc_d  = fwd_wrap ? fwd_sub[ACC_W-1:0] : fwd_raw[ACC_W-1:0];
      end else begin
        wrap_o = rev_wrap;
        acc_d  = rev_wrap ? rev_add[ACC_W-1:0] : rev_raw[ACC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else              acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_o == '0));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !clear_i |=> $stable(acc_o));
endmodule

// File: rtl/fps_pulse_reg.sv
module fps_pulse_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic fire_i,
  input  logic dir_i,
  output logic pulse_o,
  output logic dir_o
);
  import fps_pkg::*;
  logic pulse_q;
  logic dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      dir_q   <= DIR_FWD;
    end else begin
      pulse_q <= step_i && fire_i;
      if (step_i) dir_q <= dir_i;
    end
  end

  assign pulse_o = pulse_q;
  assign dir_o   = dir_q;

  assert_out_follows_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(step_i));
  assert_dir_matches_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (dir_o == $past(dir_i)));
endmodule

// File: rtl/frac_pulse_scaler.sv
module frac_pulse_scaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pulse_i,
  input  logic         dir_i,
  input  logic         load_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         pulse_o,
  output logic         dir_o
);
  logic [W-1:0] num_r, den_r;
  logic         ratio_ok;
  logic         step;
  logic         wrap;
  logic [W:0]   acc;

  fps_ratio_reg #(.W(W)) u_ratio (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .num_i(num_i), .den_i(den_i),
    .num_o(num_r), .den_o(den_r), .valid_o(ratio_ok)
  );

  // load wins over a coincident step
  assign step = pulse_i && ratio_ok && !load_i;

  fps_mod_acc #(.W(W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load_i),
    .step_i(step), .dir_i(dir_i),
    .num_i(num_r), .den_i(den_r),
    .wrap_o(wrap), .acc_o(acc)
  );

  fps_pulse_reg u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step),
    .fire_i(wrap), .dir_i(dir_i),
    .pulse_o(pulse_o), .dir_o(dir_o)
  );

  assert_acc_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_ok |-> (acc < {1'b0, den_r}));
  assert_silent_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ratio_ok |=> !pulse_o);
  assert_no_pulse_on_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !pulse_o);
endmodule

// File: tb/frac_pulse_scaler_tb.sv
module frac_pulse_scaler_tb_top;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pulse_i = 1'b0;
  logic         dir_i = 1'b1;
  logic         load_i = 1'b0;
  logic [W-1:0] num_i = '0;
  logic [W-1:0] den_i = '0;
  logic         pulse_o, dir_o;

  int checks = 0;
  int fails  = 0;
  logic got_p, got_d;

  always #5 clk_i = ~clk_i;

  frac_pulse_scaler #(.W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_i), .dir_i(dir_i),
    .load_i(load_i), .num_i(num_i), .den_i(den_i),
    .pulse_o(pulse_o), .dir_o(dir_o)
  );

  // num, den, steps, dir, expected outputs
  localparam int NV = 7;
  localparam int vec_tbl [NV][5] = '{
    '{5, 13, 13, 1, 5},
    '{5, 13, 26, 1, 10},
    '{1, 2, 10, 1, 5},
    '{3, 7, 14, 1, 6},
    '{5, 13, 13, 0, 5},
    '{7, 8, 8, 0, 7},
    '{1, 255, 255, 1, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: apply inputs on falling edge, read outputs on the next one
  task automatic cyc(input logic p, input logic d, input logic ld,
                     input int n, input int dn);
    pulse_i = p; dir_i = d; load_i = ld;
    num_i = W'(n); den_i = W'(dn);
    @(negedge clk_i);
    got_p = pulse_o; got_d = dir_o;
    pulse_i = 1'b0; load_i = 1'b0;
  endtask

  task automatic load(input int n, input int dn);
    cyc(1'b0, 1'b1, 1'b1, n, dn);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    int cnt, dir_bad;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R1 pulse_o reset", int'(pulse_o), 0);
    check("R1 dir_o reset", int'(dir_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 0, 0);
      cnt += int'(got_p);
    end
    check("R1 silent before load", cnt, 0);

    // table walk (R5, R3, R4)
    for (int v = 0; v < NV; v++) begin
      load(vec_tbl[v][0], vec_tbl[v][1]);
      cnt = 0; dir_bad = 0;
      for (int s = 0; s < vec_tbl[v][2]; s++) begin
        cyc(1'b1, logic'(vec_tbl[v][3]), 1'b0, 0, 0);
        if (got_p) begin
          cnt++;
          if (int'(got_d) != vec_tbl[v][3]) dir_bad++;
        end
      end
      check($sformatf("R5 count vec%0d", v), cnt, vec_tbl[v][4]);
      check($sformatf("R8 dir vec%0d", v), dir_bad, 0);
    end

    // R3 exact forward positions for 5/13
    load(5, 13);
    for (int s = 1; s <= 13; s++) begin
      cyc(1'b1, 1'b1, 1'b0, 0, 0);
      check($sformatf("R3 fwd step %0d", s), int'(got_p),
            (s == 3 || s == 6 || s == 8 || s == 11 || s == 13) ? 1 : 0);
    end
    // R4 exact reverse positions for 5/13
    load(5, 13);
    for (int s = 1; s <= 13; s++) begin
      cyc(1'b1, 1'b0, 1'b0, 0, 0);
      check($sformatf("R4 rev step %0d", s), int'(got_p),
            (s == 1 || s == 3 || s == 6 || s == 8 || s == 11) ? 1 : 0);
    end

    // R6 reversal keeps residue
    load(5, 13);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    check("R6 third forward fires", int'(got_p), 1);
    cyc(1'b1, 1'b0, 1'b0, 0, 0);
    check("R6 reverse fires", int'(got_p), 1);
    check("R6 reverse dir", int'(got_d), 0);
    cyc(1'b0, 1'b1, 1'b0, 0, 0);
    check("R8 dir_o holds", int'(got_d), 0);
    check("R9 idle no pulse", int'(got_p), 0);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    check("R6 forward fires from 10", int'(got_p), 1);
    check("R8 dir forward", int'(got_d), 1);

    // R9 idle gap keeps accumulator: 1/2, one step, idle, one step
    load(1, 2);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    check("R9 first step silent", int'(got_p), 0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, 0, 0);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    check("R9 residue kept over idle", int'(got_p), 1);

    // R2 load clears and swallows coincident step
    load(1, 2);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    cyc(1'b1, 1'b1, 1'b1, 1, 2);
    check("R2 step during load ignored", int'(got_p), 0);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    check("R2 accumulator cleared", int'(got_p), 0);
    cyc(1'b1, 1'b1, 1'b0, 0, 0);
    check("R2 fires after clear", int'(got_p), 1);
    cyc(1'b0, 1'b1, 1'b0, 0, 0);
    check("R8 single cycle pulse", int'(got_p), 0);

    // R7 unusable ratios
    load(3, 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin cyc(1'b1, logic'(i % 2), 1'b0, 0, 0); cnt += int'(got_p); end
    check("R7 den zero silent", cnt, 0);
    load(5, 5);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin cyc(1'b1, logic'(i % 2), 1'b0, 0, 0); cnt += int'(got_p); end
    check("R7 num>=den silent", cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule